// File: doc/BRIEF.md
# Manchester Auxiliary-Line Frame Transmitter

This block serializes a small byte buffer into one Manchester-coded frame on a single-ended auxiliary line. A frame is a run of coded zeros used by the far end to lock on, a sync-end marker, the payload bytes with the most significant bit of each byte first, and a stop marker. After the stop marker the block releases the line and pulses a done strobe.

Timing comes from a half-bit enable that an outside divider supplies. Each half of a bit cell lasts from one clock with the enable high to the next. The sender picks a long (26 zeros) or short (16 zeros) lock-on run for each frame. A separate compliance mode holds the line driven with an endless stream of coded zeros for electrical measurement.

Top module: `mtx_aux_tx`

## Requirements
- R1: After reset, and whenever no frame or test is running, line_oe is 0, line_out is 0 and done is 0.
- R2: A start pulse seen while idle sets line_oe to 1 from the next clock. Each half-bit level then holds until a clock on which hb_tick is 1 moves it on to the next half.
- R3: With short_sync at 0 when start is seen, the frame begins with 26 coded zeros. A coded zero is a low half followed by a high half.
- R4: With short_sync at 1 when start is seen, the lock-on run is 16 coded zeros.
- R5: The sync-end marker follows the lock-on run. It is four halves high and then four halves low, with no mid-cell transition.
- R6: The payload is sent as byte 0 first, then byte 1, and so on, where byte i is data_buf[8i+7:8i]. Each byte goes MSB first. A 1 is coded as high then low, and a 0 as low then high.
- R7: byte_count sets how many payload bytes are sent. A value of 0 sends no payload, so the stop marker follows the sync-end marker at once. Any value above 20 is treated as 20.
- R8: The stop marker, with the same four-high, four-low shape, follows the last payload bit. On the clock after its last half, line_oe falls and done is 1 for exactly that one clock.
- R9: start is ignored while a frame or the compliance mode is running. byte_count, short_sync and data_buf are sampled only on the accepted start, so changing them mid-frame has no effect on the frame.
- R10: When zero_test is 1 while idle, line_oe rises and coded zeros are sent without end. When zero_test returns to 0, the block goes idle on the next clock, and done stays 0.
- R11: During a frame, clocks without hb_tick change neither line_out nor line_oe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hb_tick | input | 1 | Half-bit enable; advances the line by one half |
| start | input | 1 | Frame request, accepted only when idle |
| short_sync | input | 1 | Selects the 16-zero lock-on run instead of 26 |
| zero_test | input | 1 | Compliance mode: endless coded zeros |
| byte_count | input | 5 | Number of payload bytes, 0 to 20 |
| data_buf | input | 160 | Payload; byte i in bits [8i+7:8i] |
| line_out | output | 1 | Coded line level |
| line_oe | output | 1 | Line drive enable |
| done | output | 1 | One-clock pulse at frame end |

## Verification
The line level is produced by logic that reads only registers. A half therefore appears on the clock after the edge that enters it and is complete by the next clock that carries hb_tick. The scoreboard monitor samples line_out exactly once per half, at the falling edge of every clock where hb_tick and line_oe are both high, and compares it with the next queued level. done and the fall of line_oe are due one clock after the last stop half has been sampled, so the driver checks them at the following falling edge and checks at the falling edge after that that done has cleared. In compliance mode, the return to idle is checked one clock after zero_test is cleared.

// File: rtl/mtx_pkg.sv
package mtx_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_TEST,
        PH_PRE,
        PH_SYNC,
        PH_DATA,
        PH_STOP
    } phase_e;

    // halves in a sync-end or stop marker: four high then four low
    localparam int MARK_HALVES = 8;
    localparam int MARK_HIGH   = 4;

endpackage

// File: rtl/mtx_bit_pick.sv
module mtx_bit_pick #(
    parameter int BUF_W = 160,
    parameter int HC_W  = 9
) (
    input  logic [BUF_W-1:0] dbuf,
    input  logic [HC_W-1:0]  hcnt,
    output logic             bit_o
);
    localparam int PW = $clog2(BUF_W);

    int bit_idx;
    int pos;

    // payload bit number is the half count without its half flag;
    // byte 0 leads, each byte MSB first
    always_comb begin
        bit_idx = int'(hcnt[HC_W-1:1]);
        pos     = (bit_idx / 8) * 8 + 7 - (bit_idx % 8);
        if (pos < BUF_W) begin
            bit_o = dbuf[pos[PW-1:0]];
        end else begin
            bit_o = 1'b0;
        end
    end

endmodule

// File: rtl/mtx_line_enc.sv
module mtx_line_enc
    import mtx_pkg::*;
#(
    parameter int HC_W = 9
) (
    input  phase_e          phase,
    input  logic [HC_W-1:0] hcnt,
    input  logic            data_bit,
    output logic            line_o
);
    always_comb begin
        case (phase)
            PH_TEST, PH_PRE: line_o = hcnt[0];            // coded 0: low, high
            PH_SYNC, PH_STOP: line_o = (int'(hcnt) < MARK_HIGH);
            PH_DATA:          line_o = data_bit ^ hcnt[0]; // 1: high, low
            default:          line_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/mtx_seq.sv
module mtx_seq
    import mtx_pkg::*;
#(
    parameter int MAX_BYTES = 20,
    parameter int LONG_PRE  = 26,
    parameter int SHORT_PRE = 16,
    parameter int CNT_W     = 5,
    parameter int HC_W      = 9,
    parameter int BUF_W     = 160
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hb_tick,
    input  logic             start,
    input  logic             short_sync,
    input  logic             zero_test,
    input  logic [CNT_W-1:0] byte_count,
    input  logic [BUF_W-1:0] data_buf,
    output phase_e           phase_o,
    output logic [HC_W-1:0]  hcnt_o,
    output logic [BUF_W-1:0] dbuf_o,
    output logic             done_o
);
    typedef struct packed {
        phase_e           phase;
        logic [HC_W-1:0]  hcnt;
        logic [CNT_W-1:0] nbytes;
        logic             shrt;
        logic [BUF_W-1:0] dbuf;
        logic             done;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [HC_W-1:0] last_idx;
    logic            at_last;

    // index of the final half of the current phase
    always_comb begin
        case (seq_q.phase)
            PH_PRE:  last_idx = seq_q.shrt ? HC_W'(2 * SHORT_PRE - 1)
                                           : HC_W'(2 * LONG_PRE - 1);
            PH_DATA: last_idx = HC_W'(int'(seq_q.nbytes) * 16 - 1);
            default: last_idx = HC_W'(MARK_HALVES - 1);
        endcase
        at_last = (seq_q.hcnt == last_idx);
    end

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        case (seq_q.phase)
            PH_IDLE: begin
                if (zero_test) begin
                    seq_d.phase = PH_TEST;
                    seq_d.hcnt  = '0;
                end else if (start) begin
                    seq_d.phase  = PH_PRE;
                    seq_d.hcnt   = '0;
                    seq_d.nbytes = (byte_count > CNT_W'(MAX_BYTES))
                                   ? CNT_W'(MAX_BYTES) : byte_count;
                    seq_d.shrt   = short_sync;
                    seq_d.dbuf   = data_buf;
                end
            end
            PH_TEST: begin
                if (!zero_test) begin
                    seq_d.phase = PH_IDLE;
                end else if (hb_tick) begin
                    seq_d.hcnt = seq_q.hcnt + 1'b1;
                end
            end
            default: begin
                if (hb_tick) begin
                    if (at_last) begin
                        seq_d.hcnt = '0;
                        case (seq_q.phase)
                            PH_PRE:  seq_d.phase = PH_SYNC;
                            PH_SYNC: seq_d.phase = (seq_q.nbytes == '0)
                                                   ? PH_STOP : PH_DATA;
                            PH_DATA: seq_d.phase = PH_STOP;
                            default: begin
                                seq_d.phase = PH_IDLE;
                                seq_d.done  = 1'b1;
                            end
                        endcase
                    end else begin
                        seq_d.hcnt = seq_q.hcnt + 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{phase: PH_IDLE, hcnt: '0, nbytes: '0, shrt: 1'b0,
                       dbuf: '0, done: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign phase_o = seq_q.phase;
    assign hcnt_o  = seq_q.hcnt;
    assign dbuf_o  = seq_q.dbuf;
    assign done_o  = seq_q.done;

    assert_done_after_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.done |-> $past(seq_q.phase) == PH_STOP);

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.done |=> !seq_q.done);

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase != PH_IDLE && start)
        |=> $stable(seq_q.nbytes) && $stable(seq_q.dbuf) && $stable(seq_q.shrt));

    assert_hold_no_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase != PH_IDLE && seq_q.phase != PH_TEST && !hb_tick)
        |=> $stable(seq_q.phase) && $stable(seq_q.hcnt));

    assert_test_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase == PH_TEST && !zero_test)
        |=> seq_q.phase == PH_IDLE && !seq_q.done);

    assert_byte_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        int'(seq_q.nbytes) <= MAX_BYTES);

endmodule

// File: rtl/mtx_aux_tx.sv
module mtx_aux_tx
    import mtx_pkg::*;
#(
    parameter int MAX_BYTES = 20,
    parameter int LONG_PRE  = 26,
    parameter int SHORT_PRE = 16,
    parameter int BYTE_W    = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              hb_tick,
    input  logic                              start,
    input  logic                              short_sync,
    input  logic                              zero_test,
    input  logic [$clog2(MAX_BYTES+1)-1:0]    byte_count,
    input  logic [MAX_BYTES*BYTE_W-1:0]       data_buf,
    output logic                              line_out,
    output logic                              line_oe,
    output logic                              done
);
    localparam int CNT_W     = $clog2(MAX_BYTES + 1);
    localparam int BUF_W     = MAX_BYTES * BYTE_W;
    localparam int DATA_HALF = BUF_W * 2;
    localparam int PRE_HALF  = 2 * LONG_PRE;
    localparam int MAX_HALF  = (DATA_HALF > PRE_HALF) ? DATA_HALF : PRE_HALF;
    localparam int HC_W      = (MAX_HALF > MARK_HALVES) ? $clog2(MAX_HALF)
                                                        : $clog2(MARK_HALVES);

    phase_e           phase;
    logic [HC_W-1:0]  hcnt;
    logic [BUF_W-1:0] dbuf;
    logic             data_bit;
    logic             line_lvl;

    mtx_seq #(
        .MAX_BYTES (MAX_BYTES),
        .LONG_PRE  (LONG_PRE),
        .SHORT_PRE (SHORT_PRE),
        .CNT_W     (CNT_W),
        .HC_W      (HC_W),
        .BUF_W     (BUF_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .hb_tick    (hb_tick),
        .start      (start),
        .short_sync (short_sync),
        .zero_test  (zero_test),
        .byte_count (byte_count),
        .data_buf   (data_buf),
        .phase_o    (phase),
        .hcnt_o     (hcnt),
        .dbuf_o     (dbuf),
        .done_o     (done)
    );

    mtx_bit_pick #(
        .BUF_W (BUF_W),
        .HC_W  (HC_W)
    ) u_pick (
        .dbuf  (dbuf),
        .hcnt  (hcnt),
        .bit_o (data_bit)
    );

    mtx_line_enc #(
        .HC_W (HC_W)
    ) u_enc (
        .phase    (phase),
        .hcnt     (hcnt),
        .data_bit (data_bit),
        .line_o   (line_lvl)
    );

    // R1/R2: line is driven exactly while a frame or test runs
    assign line_oe  = (phase != PH_IDLE);
    assign line_out = line_lvl;

    assert_mid_cell_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DATA && hb_tick && !hcnt[0]) |=> line_out != $past(line_out));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !line_oe |-> !line_out);

    assert_oe_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_oe && start && !zero_test) |=> line_oe);

endmodule

// File: tb/mtx_aux_tx_test.sv
module mtx_aux_tx_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         hb_tick = 1'b0;
    logic         start = 1'b0;
    logic         short_sync = 1'b0;
    logic         zero_test = 1'b0;
    logic [4:0]   byte_count = '0;
    logic [159:0] data_buf = '0;
    logic         line_out;
    logic         line_oe;
    logic         done;

    int total = 0;
    int bad = 0;
    bit tick_en = 1'b1;
    bit finished = 1'b0;

    typedef struct {
        bit lvl;
        int req;
    } half_t;
    half_t exp_q[$];

    mtx_aux_tx uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .hb_tick    (hb_tick),
        .start      (start),
        .short_sync (short_sync),
        .zero_test  (zero_test),
        .byte_count (byte_count),
        .data_buf   (data_buf),
        .line_out   (line_out),
        .line_oe    (line_oe),
        .done       (done)
    );

    always #10 clk = ~clk;  // 50 MHz

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // half-bit enable: one clock in four
    initial begin
        int tcnt = 0;
        forever begin
            @(posedge clk);
            #1;
            tcnt++;
            hb_tick = tick_en && (tcnt % 4 == 0);
        end
    end

    // monitor: one sample per half, just before the edge that ends it
    always @(negedge clk) begin
        if (rst_n && hb_tick && line_oe) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected half", int'(line_out), -1);
            end else begin
                half_t h;
                h = exp_q.pop_front();
                check(line_out == h.lvl, $sformatf("R%0d line", h.req),
                      int'(line_out), int'(h.lvl));
            end
        end
    end

    task automatic push_half(input bit lvl, input int req);
        half_t h;
        h.lvl = lvl;
        h.req = req;
        exp_q.push_back(h);
    endtask

    task automatic push_marker(input int req);
        for (int i = 0; i < 8; i++) push_half(i < 4, req);  // R5 / R8 shape
    endtask

    task automatic launch(input int nb, input bit shrt, input logic [159:0] dat);
        int zeros;
        int eff;
        zeros = shrt ? 16 : 26;
        for (int i = 0; i < zeros; i++) begin
            push_half(1'b0, shrt ? 4 : 3);
            push_half(1'b1, shrt ? 4 : 3);
        end
        push_marker(5);
        eff = (nb > 20) ? 20 : nb;  // R7 clamp
        for (int b = 0; b < eff; b++) begin
            for (int k = 7; k >= 0; k--) begin
                bit v;
                v = dat[b*8 + k];   // R6 byte 0 first, MSB first
                push_half(v, 6);
                push_half(~v, 6);
            end
        end
        push_marker(8);
        @(posedge clk); #1;
        start = 1'b1;
        byte_count = 5'(nb);
        short_sync = shrt;
        data_buf = dat;
        @(posedge clk); #1;
        start = 1'b0;
        check(line_oe == 1'b1, "R2 oe after start", int'(line_oe), 1);
    endtask

    task automatic finish_frame();
        while (exp_q.size() != 0) begin
            @(negedge clk); #1;
        end
        @(negedge clk);
        check(done == 1'b1, "R8 done pulse", int'(done), 1);
        check(line_oe == 1'b0, "R8 oe released", int'(line_oe), 0);
        @(negedge clk);
        check(done == 1'b0, "R8 done one clock", int'(done), 0);
    endtask

    task automatic quiet(input int n, input string req);
        bit ok = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (line_oe || line_out || done) ok = 1'b0;
        end
        check(ok, req, int'(line_oe), 0);
    endtask

    initial begin
        logic [159:0] pat;
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        check(line_oe == 1'b0, "R1 reset oe", int'(line_oe), 0);
        check(line_out == 1'b0, "R1 reset line", int'(line_out), 0);
        check(done == 1'b0, "R1 reset done", int'(done), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        quiet(10, "R1 idle quiet");

        // R3 long lock-on, three bytes
        launch(3, 1'b0, 160'h0000_0000_0000_0000_0000_0000_0000_0000_003C_A5F0);
        finish_frame();

        // R4 short lock-on, one byte of mixed bits
        launch(1, 1'b1, 160'h81);
        finish_frame();

        // R7 zero bytes: stop marker right after sync-end
        launch(0, 1'b0, '1);
        finish_frame();

        // R7 over-range count sends twenty bytes
        pat = '0;
        for (int i = 0; i < 20; i++) pat[i*8 +: 8] = 8'(i * 37 + 5);
        launch(25, 1'b1, pat);
        finish_frame();

        // R9 start ignored mid-frame; R11 hold without ticks
        launch(2, 1'b0, 160'hC3_5A);
        repeat (30) @(posedge clk);
        #1;
        start = 1'b1;
        byte_count = 5'd5;
        short_sync = 1'b1;
        data_buf = '1;
        @(posedge clk); #1;
        start = 1'b0;
        tick_en = 1'b0;
        @(negedge clk);
        begin
            bit lv;
            bit ok = 1'b1;
            lv = line_out;
            for (int i = 0; i < 12; i++) begin
                @(negedge clk);
                if (line_out != lv || !line_oe) ok = 1'b0;
            end
            check(ok, "R11 hold without tick", int'(line_out), int'(lv));
        end
        @(posedge clk); #1;
        tick_en = 1'b1;
        finish_frame();
        quiet(20, "R9 late start ignored");

        // R10 compliance zeros, start ignored during it
        for (int i = 0; i < 12; i++) begin
            push_half(1'b0, 10);
            push_half(1'b1, 10);
        end
        @(posedge clk); #1;
        zero_test = 1'b1;
        repeat (6) @(posedge clk);
        #1;
        start = 1'b1;
        byte_count = 5'd1;
        @(posedge clk); #1;
        start = 1'b0;
        while (exp_q.size() != 0) begin
            @(negedge clk); #1;
        end
        zero_test = 1'b0;
        @(negedge clk);
        check(line_oe == 1'b0, "R10 test exit", int'(line_oe), 0);
        check(done == 1'b0, "R10 no done", int'(done), 0);
        quiet(20, "R9 start during test ignored");

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "R2 watchdog", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule